// File: doc/BRIEF.md
# Special Register Read Unit

This unit answers read-only special-register requests from an in-order issue stage. Special registers live outside the general register file and take no general register allocation. Two kinds exist, and each has its own path. Values shared by every lane are a free-running 64-bit cycle counter and a 64-bit wall-clock timestamp that advances on an external tick. They are produced next to the issue stage and return on a fixed-latency writeback port one cycle after issue.

Values that differ per lane sit in a separate per-lane bank. These are the lane number and a small set of per-thread entries such as thread and block coordinates, which launch logic fills through a load port. To reach the bank, a request must first win a crossbar that it shares round-robin with one other requester. The result then returns on a variable-latency writeback port.

A scoreboard with one pending bit per destination register covers the variable-latency path. It holds back any later instruction that names a pending register as a source or as its destination. The result can go to a per-lane destination or to a warp-uniform destination, and each destination space has its own pending bits.

Top module: `sr_read_unit`

## Requirements
- R1: A 64-bit read of ID 0 returns the cycle counter on `fx_lo`/`fx_hi` with both halves taken in the same cycle. The value is `CLK_INIT` plus the number of clock edges since reset was released, counted up to the accepting edge. The carry from the low half into the high half appears in that same read.
- R2: A 32-bit read (`iss_wide`=0) of ID 0 or ID 1 returns only the low half, and `fx_hi` is zero.
- R3: ID 1 returns the wall-clock timestamp. Its value is `TIME_INIT` plus the number of edges at which `time_tick` was high.
- R4: Fixed-path reads (IDs 0, 1 and undefined IDs) raise `fx_valid` in the cycle after acceptance, with the destination echoed. They set no pending bit and are never stalled by an outstanding variable-latency read.
- R5: An undefined ID (7 to 15) returns zero data on the fixed port and raises `sr_err` for exactly that one cycle.
- R6: ID 2 returns the lane number in each lane's 32-bit slice `vx_data[32k+31:32k]`.
- R7: IDs 3 to 6 return, in each lane k, the value loaded for lane k at bank entry 0 to 3 respectively.
- R8: An accepted variable-latency read (IDs 2 to 6) sets the pending bit of its destination. `iss_ready` stays low while `iss_src_a`, `iss_src_b` or the destination `{iss_dst_uni, iss_dst}` names a pending register. It rises in the cycle `vx_valid` is high.
- R9: The crossbar grants one requester per cycle and alternates when both request, so the unit waits while the other requester holds the grant. With no contention, `vx_valid` rises on the second cycle after acceptance; losing one arbitration adds one cycle.
- R10: When a per-lane read targets a warp-uniform destination, lane 0's value is placed in every lane slice.
- R11: Pending bits of the per-lane and warp-uniform register spaces are separate. Register index MSB 1 selects the uniform space.
- R12: Only one variable-latency read is outstanding at a time. A second one stalls until the first writes back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue stage presents an instruction |
| iss_sreg | input | 1 | 1: special-register read; 0: other instruction (scoreboard check only) |
| iss_id | input | 4 | Special-register ID |
| iss_wide | input | 1 | 64-bit read of a uniform counter |
| iss_dst_uni | input | 1 | Destination is warp-uniform |
| iss_dst | input | RW | Destination register index |
| iss_src_a | input | RW+1 | Source A, MSB selects uniform space |
| iss_src_b | input | RW+1 | Source B, MSB selects uniform space |
| iss_ready | output | 1 | Instruction may issue this cycle |
| time_tick | input | 1 | Advance wall-clock timestamp |
| ld_we | input | 1 | Per-lane bank load strobe |
| ld_lane | input | LW | Lane to load |
| ld_idx | input | BW | Bank entry to load |
| ld_data | input | 32 | Load value |
| oth_req | input | 1 | Competing crossbar request |
| oth_gnt | output | 1 | Crossbar granted to competing requester |
| fx_valid | output | 1 | Fixed-path writeback valid |
| fx_dst | output | RW | Fixed-path destination |
| fx_dst_uni | output | 1 | Fixed-path destination is uniform |
| fx_lo | output | 32 | Low half of result |
| fx_hi | output | 32 | High half of result |
| sr_err | output | 1 | Undefined ID read |
| vx_valid | output | 1 | Variable-path writeback valid |
| vx_dst | output | RW | Variable-path destination |
| vx_dst_uni | output | 1 | Variable-path destination is uniform |
| vx_data | output | LANES*32 | Per-lane results |

## Verification
The bench sets the counter start just below a 32-bit boundary and takes back-to-back 64-bit reads across the wrap. A design that latched the halves in different cycles, or lost the carry, would return a high half that is off by one. It then probes the stall window one cycle at a time, through both sources, the destination and the other register space: a scoreboard that cleared late, cleared early or merged the two spaces would show the wrong `iss_ready`. It raises the competing request exactly when the unit starts to request. A fixed-priority arbiter would then show the wrong latency or the wrong `oth_gnt`. Undefined IDs and a uniform destination for a per-lane read are mixed into random traffic, so a leftover error flag or lane data that is not broadcast would show up.

// File: rtl/sr_pkg.sv
package sr_pkg;
  localparam int SRID_W = 4;
  typedef logic [SRID_W-1:0] srid_t;

  // Uniform counters, then the hardwired lane number, then bank entries.
  localparam srid_t SRID_CYCLE = 4'd0;
  localparam srid_t SRID_WALL  = 4'd1;
  localparam srid_t SRID_LANE  = 4'd2;
  localparam srid_t SRID_BANK0 = 4'd3;

  function automatic logic is_lane_path(input srid_t id, input int nbank);
    return (int'(id) >= int'(SRID_LANE)) && (int'(id) < int'(SRID_BANK0) + nbank);
  endfunction
endpackage

// File: rtl/sr_fixed_path.sv
module sr_fixed_path
  import sr_pkg::*;
#(
  parameter logic [63:0] CLK_INIT  = 64'd0,
  parameter logic [63:0] TIME_INIT = 64'd0,
  parameter int          RW        = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          rd_en,
  input  srid_t         rd_id,
  input  logic          rd_wide,
  input  logic          rd_bad,
  input  logic [RW-1:0] rd_dst,
  input  logic          rd_uni,
  output logic          fx_valid,
  output logic [RW-1:0] fx_dst,
  output logic          fx_uni,
  output logic [31:0]   fx_lo,
  output logic [31:0]   fx_hi,
  output logic          err
);
  logic [63:0] cyc_q;
  logic [63:0] wall_q;
  logic [63:0] pick;

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q  <= CLK_INIT;
      wall_q <= TIME_INIT;
    end else begin
      cyc_q <= cyc_q + 64'd1;
      if (tick) wall_q <= wall_q + 64'd1;
    end
  end

  // One 64-bit snapshot feeds both halves, so they always match in time.
  always_comb begin
    unique case (rd_id)
      SRID_CYCLE: pick = cyc_q;
      SRID_WALL:  pick = wall_q;
      default:    pick = 64'd0;
    endcase
    if (rd_bad) pick = 64'd0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fx_valid <= 1'b0;
      err      <= 1'b0;
      fx_dst   <= '0;
      fx_uni   <= 1'b0;
      fx_lo    <= '0;
      fx_hi    <= '0;
    end else begin
      fx_valid <= rd_en;
      err      <= rd_en && rd_bad;
      if (rd_en) begin
        fx_dst <= rd_dst;
        fx_uni <= rd_uni;
        fx_lo  <= pick[31:0];
        fx_hi  <= rd_wide ? pick[63:32] : 32'd0;
      end
    end
  end
endmodule

// File: rtl/sr_lane_bank.sv
module sr_lane_bank #(
  parameter int LANES = 4,
  parameter int DEPTH = 4,
  parameter int DW    = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [LW-1:0]       wlane,
  input  logic [BW-1:0]       widx,
  input  logic [DW-1:0]       wdata,
  input  logic                re,
  input  logic [BW-1:0]       ridx,
  input  logic                rsel_lane,
  output logic [LANES*DW-1:0] rdata
);
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int BW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic sel_q;

  always_ff @(posedge clk) begin
    if (rst)     sel_q <= 1'b0;
    else if (re) sel_q <= rsel_lane;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] q;

    // Simple dual-port, registered read: maps onto block RAM.
    always_ff @(posedge clk) begin
      if (we && wlane == LW'(g)) mem[widx] <= wdata;
      if (re) q <= mem[ridx];
    end

    assign rdata[g*DW +: DW] = sel_q ? DW'(g) : q;
  end
endmodule

// File: rtl/sr_xbar_arb.sv
module sr_xbar_arb (
  input  logic clk,
  input  logic rst,
  input  logic req_a,
  input  logic req_b,
  output logic gnt_a,
  output logic gnt_b
);
  logic last_b;

  assign gnt_a = req_a && (!req_b || last_b);
  assign gnt_b = req_b && (!req_a || !last_b);

  always_ff @(posedge clk) begin
    if (rst)                 last_b <= 1'b1;
    else if (gnt_a || gnt_b) last_b <= gnt_b;
  end
endmodule

// File: rtl/sr_scoreboard.sv
module sr_scoreboard #(
  parameter int NREGS = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_en,
  input  logic [IW-1:0] set_idx,
  input  logic          clr_en,
  input  logic [IW-1:0] clr_idx,
  input  logic [IW-1:0] q_a,
  input  logic [IW-1:0] q_b,
  input  logic [IW-1:0] q_c,
  output logic          busy
);
  localparam int IW = $clog2(NREGS) + 1;

  logic [2*NREGS-1:0] pend;
  logic [2*NREGS-1:0] pend_n;

  always_comb begin
    pend_n = pend;
    if (clr_en) pend_n[clr_idx] = 1'b0;
    if (set_en) pend_n[set_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= pend_n;
  end

  assign busy = pend[q_a] || pend[q_b] || pend[q_c];
endmodule

// File: rtl/sr_read_unit.sv
module sr_read_unit
  import sr_pkg::*;
#(
  parameter int          LANES     = 4,
  parameter int          NREGS     = 32,
  parameter int          BANK_REGS = 4,
  parameter logic [63:0] CLK_INIT  = 64'd0,
  parameter logic [63:0] TIME_INIT = 64'd0,
  localparam int         RW        = $clog2(NREGS),
  localparam int         LW        = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int         BW        = (BANK_REGS > 1) ? $clog2(BANK_REGS) : 1,
  localparam int         DW        = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                iss_valid,
  input  logic                iss_sreg,
  input  logic [SRID_W-1:0]   iss_id,
  input  logic                iss_wide,
  input  logic                iss_dst_uni,
  input  logic [RW-1:0]       iss_dst,
  input  logic [RW:0]         iss_src_a,
  input  logic [RW:0]         iss_src_b,
  output logic                iss_ready,
  input  logic                time_tick,
  input  logic                ld_we,
  input  logic [LW-1:0]       ld_lane,
  input  logic [BW-1:0]       ld_idx,
  input  logic [DW-1:0]       ld_data,
  input  logic                oth_req,
  output logic                oth_gnt,
  output logic                fx_valid,
  output logic [RW-1:0]       fx_dst,
  output logic                fx_dst_uni,
  output logic [DW-1:0]       fx_lo,
  output logic [DW-1:0]       fx_hi,
  output logic                sr_err,
  output logic                vx_valid,
  output logic [RW-1:0]       vx_dst,
  output logic                vx_dst_uni,
  output logic [LANES*DW-1:0] vx_data
);
  logic is_var, is_bad, hazard;
  logic acc, acc_fix, acc_var;
  logic sr_req, gnt_sr;

  logic          vreq_valid, vrd_q, vreq_uni;
  srid_t         vreq_id;
  logic [RW-1:0] vreq_dst;
  srid_t         boff;
  logic [LANES*DW-1:0] bank_rd, bcast;

  assign is_var = is_lane_path(iss_id, BANK_REGS);
  assign is_bad = !is_var && (iss_id != SRID_CYCLE) && (iss_id != SRID_WALL);

  assign iss_ready = !hazard && !(iss_sreg && is_var && vreq_valid);
  assign acc       = iss_valid && iss_ready;
  assign acc_fix   = acc && iss_sreg && !is_var;
  assign acc_var   = acc && iss_sreg && is_var;

  sr_scoreboard #(.NREGS(NREGS)) u_sb (
    .clk     (clk),
    .rst     (rst),
    .set_en  (acc_var),
    .set_idx ({iss_dst_uni, iss_dst}),
    .clr_en  (vrd_q),
    .clr_idx ({vreq_uni, vreq_dst}),
    .q_a     (iss_src_a),
    .q_b     (iss_src_b),
    .q_c     ({iss_dst_uni, iss_dst}),
    .busy    (hazard)
  );

  sr_fixed_path #(.CLK_INIT(CLK_INIT), .TIME_INIT(TIME_INIT), .RW(RW)) u_fix (
    .clk      (clk),
    .rst      (rst),
    .tick     (time_tick),
    .rd_en    (acc_fix),
    .rd_id    (iss_id),
    .rd_wide  (iss_wide),
    .rd_bad   (is_bad),
    .rd_dst   (iss_dst),
    .rd_uni   (iss_dst_uni),
    .fx_valid (fx_valid),
    .fx_dst   (fx_dst),
    .fx_uni   (fx_dst_uni),
    .fx_lo    (fx_lo),
    .fx_hi    (fx_hi),
    .err      (sr_err)
  );

  assign sr_req = vreq_valid && !vrd_q;

  sr_xbar_arb u_arb (
    .clk   (clk),
    .rst   (rst),
    .req_a (sr_req),
    .req_b (oth_req),
    .gnt_a (gnt_sr),
    .gnt_b (oth_gnt)
  );

  assign boff = vreq_id - SRID_BANK0;

  sr_lane_bank #(.LANES(LANES), .DEPTH(BANK_REGS), .DW(DW)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .we        (ld_we),
    .wlane     (ld_lane),
    .widx      (ld_idx),
    .wdata     (ld_data),
    .re        (gnt_sr),
    .ridx      (BW'(boff)),
    .rsel_lane (vreq_id == SRID_LANE),
    .rdata     (bank_rd)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_bc
    assign bcast[g*DW +: DW] = vreq_uni ? bank_rd[DW-1:0] : bank_rd[g*DW +: DW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vreq_valid <= 1'b0;
      vrd_q      <= 1'b0;
      vreq_id    <= '0;
      vreq_dst   <= '0;
      vreq_uni   <= 1'b0;
      vx_valid   <= 1'b0;
      vx_dst     <= '0;
      vx_dst_uni <= 1'b0;
      vx_data    <= '0;
    end else begin
      vx_valid <= vrd_q;
      if (acc_var) begin
        vreq_valid <= 1'b1;
        vreq_id    <= iss_id;
        vreq_dst   <= iss_dst;
        vreq_uni   <= iss_dst_uni;
      end
      if (gnt_sr) vrd_q <= 1'b1;
      if (vrd_q) begin
        vreq_valid <= 1'b0;
        vrd_q      <= 1'b0;
        vx_dst     <= vreq_dst;
        vx_dst_uni <= vreq_uni;
        vx_data    <= bcast;
      end
    end
  end
endmodule

// File: rtl/sr_read_unit_chk.sv
module sr_read_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        iss_wide,
  input logic        acc_fix,
  input logic        fx_valid,
  input logic [31:0] fx_lo,
  input logic [31:0] fx_hi,
  input logic        sr_err,
  input logic        sr_req,
  input logic        gnt_sr,
  input logic        oth_gnt,
  input logic        vx_valid
);
  p_fix_lat_r4: assert property (@(posedge clk) disable iff (rst)
    acc_fix |=> fx_valid);

  p_narrow_hi_r2: assert property (@(posedge clk) disable iff (rst)
    acc_fix && !iss_wide |=> fx_hi == 32'd0);

  p_err_zero_r5: assert property (@(posedge clk) disable iff (rst)
    sr_err |-> fx_valid && fx_lo == 32'd0 && fx_hi == 32'd0);

  p_gnt_excl_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({gnt_sr, oth_gnt}));

  p_rr_turn_r9: assert property (@(posedge clk) disable iff (rst)
    sr_req && oth_gnt |=> gnt_sr);

  p_var_lat_r9: assert property (@(posedge clk) disable iff (rst)
    gnt_sr |=> ##1 vx_valid);
endmodule

bind sr_read_unit sr_read_unit_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .iss_wide (iss_wide),
  .acc_fix  (acc_fix),
  .fx_valid (fx_valid),
  .fx_lo    (fx_lo),
  .fx_hi    (fx_hi),
  .sr_err   (sr_err),
  .sr_req   (sr_req),
  .gnt_sr   (gnt_sr),
  .oth_gnt  (oth_gnt),
  .vx_valid (vx_valid)
);

// File: tb/sr_read_unit_test.sv
`timescale 1ns/1ps
module sr_read_unit_test;
  localparam int LANES = 4;
  localparam int BREGS = 4;
  localparam logic [63:0] CI = 64'h0000_0000_FFFF_FF00;
  localparam logic [63:0] TI = 64'h0000_0123_89AB_0000;

  logic clk = 1'b0, rst = 1'b1;
  logic iss_valid = 0, iss_sreg = 0, iss_wide = 0, iss_dst_uni = 0;
  logic [3:0] iss_id = 0;
  logic [4:0] iss_dst = 0;
  logic [5:0] iss_src_a = 0, iss_src_b = 0;
  logic iss_ready, time_tick = 0, ld_we = 0, oth_req = 0, oth_gnt;
  logic [1:0] ld_lane = 0, ld_idx = 0;
  logic [31:0] ld_data = 0;
  logic fx_valid, fx_dst_uni, sr_err, vx_valid, vx_dst_uni;
  logic [4:0] fx_dst, vx_dst;
  logic [31:0] fx_lo, fx_hi;
  logic [LANES*32-1:0] vx_data;

  logic [63:0] cyc = 0, tcnt = 0, ev_cyc, ev_wall;
  logic [31:0] bmod [LANES][BREGS];
  int checks = 0, errors = 0;
  bit done = 0;

  sr_read_unit #(.LANES(LANES), .NREGS(32), .BANK_REGS(BREGS),
                 .CLK_INIT(CI), .TIME_INIT(TI)) uut (.*);

  always #5 clk = ~clk;
  always @(posedge clk) if (!rst) cyc <= cyc + 64'd1;
  always @(posedge clk) if (!rst && time_tick) tcnt <= tcnt + 64'd1;
  always @(negedge clk) time_tick <= ($urandom % 3) == 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] lane_exp(input int lane, input logic [3:0] id);
    return (id == 4'd2) ? 32'(lane) : bmod[lane][id - 4'd3];
  endfunction

  task automatic issue(input logic [3:0] id, input bit wide, input logic [4:0] dst, input bit uni);
    @(negedge clk);
    iss_valid = 1; iss_sreg = 1; iss_id = id; iss_wide = wide;
    iss_dst = dst; iss_dst_uni = uni;
    iss_src_a = {uni, dst}; iss_src_b = {uni, dst};
    #1;
    while (!iss_ready) begin @(negedge clk); #1; end
    ev_cyc = CI + cyc; ev_wall = TI + tcnt;
    @(negedge clk);
    iss_valid = 0;
    #1;
  endtask

  task automatic do_fixed(input logic [3:0] id, input bit wide, input logic [4:0] dst,
                          input bit uni, input string req);
    logic [63:0] ev;
    bit bad;
    issue(id, wide, dst, uni);
    bad = id > 4'd6;
    ev = (id == 4'd0) ? ev_cyc : (id == 4'd1) ? ev_wall : 64'd0;
    if (!wide) ev[63:32] = 32'd0;
    chk(fx_valid == 1'b1, req, "fx_valid", 64'(fx_valid), 64'd1);
    chk(fx_lo == ev[31:0], req, "fx_lo", 64'(fx_lo), 64'(ev[31:0]));
    chk(fx_hi == ev[63:32], req, "fx_hi", 64'(fx_hi), 64'(ev[63:32]));
    chk(sr_err == bad, req, "sr_err", 64'(sr_err), 64'(bad));
    chk(fx_dst == dst && fx_dst_uni == uni, req, "fx_dst", 64'({fx_dst_uni, fx_dst}), 64'({uni, dst}));
  endtask

  task automatic do_var(input logic [3:0] id, input logic [4:0] dst, input bit uni,
                        input int lat, input bit rise_oth, input string req);
    int k = 0;
    issue(id, 1'b0, dst, uni);
    if (rise_oth) begin
      oth_req = 1; #1;
      chk(oth_gnt == 1'b1, "R9", "oth_gnt on contention", 64'(oth_gnt), 64'd1);
    end else if (lat == 2 && oth_req) begin
      chk(oth_gnt == 1'b0, "R9", "oth_gnt after its turn", 64'(oth_gnt), 64'd0);
    end
    while (!vx_valid && k < 40) begin @(negedge clk); #1; k++; end
    if (lat >= 0) chk(k == lat, "R9", "latency", 64'(k), 64'(lat));
    chk(vx_valid == 1'b1, req, "vx_valid", 64'(vx_valid), 64'd1);
    chk(vx_dst == dst && vx_dst_uni == uni, req, "vx_dst", 64'({vx_dst_uni, vx_dst}), 64'({uni, dst}));
    for (int l = 0; l < LANES; l++) begin
      logic [31:0] ev = lane_exp(uni ? 0 : l, id);
      chk(vx_data[l*32 +: 32] == ev, req, "lane data", 64'(vx_data[l*32 +: 32]), 64'(ev));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    #1;
    chk(fx_valid == 0 && vx_valid == 0, "R4", "reset valids", 64'({fx_valid, vx_valid}), 64'd0);
    chk(sr_err == 0, "R5", "reset err", 64'(sr_err), 64'd0);
    chk(iss_ready == 1, "R8", "reset nothing pending", 64'(iss_ready), 64'd1);
    @(negedge clk); rst = 0;

    for (int l = 0; l < LANES; l++)
      for (int i = 0; i < BREGS; i++) begin
        @(negedge clk);
        bmod[l][i] = $urandom;
        ld_we = 1; ld_lane = 2'(l); ld_idx = 2'(i); ld_data = bmod[l][i];
      end
    @(negedge clk); ld_we = 0;

    do_fixed(4'd0, 1, 5'd1, 0, "R1");
    do_fixed(4'd0, 0, 5'd2, 1, "R2");
    do_fixed(4'd1, 1, 5'd3, 0, "R3");
    do_fixed(4'd1, 0, 5'd4, 0, "R2");
    do_fixed(4'd9, 1, 5'd5, 0, "R5");
    @(negedge clk); #1;
    chk(sr_err == 0, "R5", "err one cycle", 64'(sr_err), 64'd0);
    do_fixed(4'd15, 0, 5'd6, 1, "R5");

    do_var(4'd2, 5'd8, 0, 2, 0, "R6");
    do_var(4'd3, 5'd9, 0, 2, 0, "R7");
    do_var(4'd6, 5'd10, 0, 2, 0, "R7");
    do_var(4'd4, 5'd11, 1, 2, 0, "R10");
    do_var(4'd5, 5'd12, 0, 3, 1, "R9");
    do_var(4'd3, 5'd13, 0, 2, 0, "R9");
    oth_req = 0;

    // stall window for an outstanding read to per-lane register 7
    @(negedge clk);
    iss_valid = 1; iss_sreg = 1; iss_id = 4'd4; iss_dst = 5'd7; iss_dst_uni = 0;
    iss_src_a = 6'd0; iss_src_b = 6'd0;
    @(negedge clk);
    iss_valid = 0; iss_sreg = 0; iss_dst = 5'd1; iss_src_a = 6'd7; #1;
    chk(!iss_ready, "R8", "src_a stall", 64'(iss_ready), 64'd0);
    iss_src_a = 6'd0; iss_src_b = 6'd7; #1;
    chk(!iss_ready, "R8", "src_b stall", 64'(iss_ready), 64'd0);
    iss_src_b = 6'd0; iss_src_a = {1'b1, 5'd7}; #1;
    chk(iss_ready, "R11", "uniform space independent", 64'(iss_ready), 64'd1);
    iss_src_a = 6'd0; iss_dst = 5'd7; #1;
    chk(!iss_ready, "R8", "dst stall", 64'(iss_ready), 64'd0);
    @(negedge clk);
    iss_sreg = 1; iss_id = 4'd3; iss_dst = 5'd9; #1;
    chk(!iss_ready, "R12", "second variable read", 64'(iss_ready), 64'd0);
    iss_id = 4'd0; #1;
    chk(iss_ready, "R4", "fixed read not blocked", 64'(iss_ready), 64'd1);
    iss_sreg = 0; iss_dst = 5'd1; iss_src_a = 6'd7; #1;
    chk(!iss_ready, "R8", "still pending", 64'(iss_ready), 64'd0);
    @(negedge clk); #1;
    chk(iss_ready && vx_valid, "R8", "release at writeback", 64'({iss_ready, vx_valid}), 64'd3);
    iss_src_a = 6'd0;

    do_fixed(4'd0, 1, 5'd12, 0, "R4");
    @(negedge clk);
    iss_sreg = 0; iss_src_a = 6'd12; #1;
    chk(iss_ready, "R4", "fixed sets no pending", 64'(iss_ready), 64'd1);
    iss_src_a = 6'd0;

    while (CI + cyc < 64'h0000_0000_FFFF_FFFA) @(negedge clk);
    for (int i = 0; i < 5; i++) do_fixed(4'd0, 1, 5'(i), 0, "R1");

    for (int n = 0; n < 300; n++) begin
      logic [3:0] id = 4'($urandom % 16);
      logic [4:0] dst = 5'($urandom % 32);
      bit uni = 1'($urandom % 2);
      oth_req = 1'($urandom % 2);
      if (id >= 4'd2 && id <= 4'd6) do_var(id, dst, uni, -1, 0, uni ? "R10" : "R7");
      else do_fixed(id, 1'($urandom % 2), dst, uni, (id > 4'd6) ? "R5" : "R1");
    end
    oth_req = 0;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule